// File: doc/BRIEF.md
# Bit-Oriented Message Receiver

This block watches the serial data-link bit stream of a T1 extended-superframe receiver and picks out bit-oriented messages. A message travels as a 16-bit codeword. The codeword opens with a flag of eight ones. An 8-bit field follows the flag, and that field must begin and end with a zero. Only bits presented with the valid strobe take part. Separating the data-link bits from the framing structure is done upstream and is not part of this block.

Every codeword that is recognised goes into a short history. A field value is accepted when at least eight of the last ten recognised codewords carry that value. This allows up to two corrupted or different codewords inside the window. When an accepted value differs from the one already held, the message register loads it and a sticky "message received" flag is set. A sticky "match" flag is set each time an accepted value equals a programmable match value. A one-cycle clear input drops both flags. After each codeword is recognised, the search restarts at a fresh flag, so bits are never shared between two codewords.

Top module: `bom_rx`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `msg` is 8'h00 and `msg_rx` and `msg_match` are 0.
- R2: A codeword is recognised only when eight 1 bits are followed by an 8-bit field whose first and last received bits are both 0. The first field bit received lands in `msg[7]` and the last in `msg[0]`. A field whose first or last bit is 1 is never accepted.
- R3: A value is accepted on the codeword that makes it appear in at least 8 of the last 10 recognised codewords. With only 7 occurrences, `msg` keeps its value. `msg` changes at no other time.
- R4: Up to two codewords with other values anywhere inside the 10-codeword window do not prevent acceptance. The window counts recognised codewords only.
- R5: `msg_rx` is sticky. An accepted value equal to the value already held in `msg` does not set it again.
- R6: An accepted value that differs from `msg` (or the first value accepted after reset) is loaded into `msg`. `msg_rx` is set in the same clock edge.
- R7: `msg_match` is set on every acceptance whose value equals `match_val`. It is not set when they differ.
- R8: A one-cycle `flag_clr` clears both flags and leaves `msg` unchanged. When a set and a clear fall in the same cycle, the set wins.
- R9: Cycles with `dl_vld` low are ignored whatever `dl_bit` carries. A codeword may be spread over cycles with gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dl_bit | input | 1 | Received data-link bit |
| dl_vld | input | 1 | Strobe: `dl_bit` is valid this cycle |
| match_val | input | 8 | Programmable value compared with each accepted message |
| flag_clr | input | 1 | One-cycle clear of both sticky flags |
| msg | output | 8 | Last accepted message |
| msg_rx | output | 1 | Sticky: a new message was accepted |
| msg_match | output | 1 | Sticky: an accepted message equalled `match_val` |

## Verification
The assertions check several properties on every cycle. They check that the flags stay set until a clear, that a clear without a simultaneous set empties the received flag, and that `msg` moves only on an acceptance. They also check that the register always holds zero-bounded fields, that a rising received flag always comes with a new value, and that a rising match flag follows an acceptance equal to `match_val`. Only the bench scenarios can show the counting itself. These include the exact 7-versus-8 boundary, acceptance with two interlopers in the window, the first-received bit landing in the top of the register, malformed fields never qualifying, and gaps in the valid strobe.

// File: rtl/bom_rx.sv
module bom_rx #(
  parameter int W     = 8,
  parameter int FL    = 8,
  parameter int DEPTH = 10,
  parameter int NEED  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dl_bit,
  input  logic         dl_vld,
  input  logic [W-1:0] match_val,
  input  logic         flag_clr,
  output logic [W-1:0] msg,
  output logic         msg_rx,
  output logic         msg_match
);
  localparam int SW = FL + W;
  localparam int HN = DEPTH - 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [SW-1:0] sr;
  logic [W-1:0]  hist [HN];
  logic [HN-1:0] hv;
  logic          have_q;
  logic [CW-1:0] hits;

  wire [SW-1:0] sr_n = {sr[SW-2:0], dl_bit};
  wire [W-1:0]  cand = sr_n[W-1:0];
  wire          cw   = dl_vld && (&sr_n[SW-1:W]) && !sr_n[W-1] && !sr_n[0];

  always_comb begin
    hits = CW'(1);
    for (int i = 0; i < HN; i++)
      if (hv[i] && hist[i] == cand) hits = hits + CW'(1);
  end

  wire qual = cw && (hits >= CW'(NEED));
  wire upd  = qual && (!have_q || cand != msg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (dl_vld) sr <= cw ? '0 : sr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HN; i++) hist[i] <= '0;
      hv <= '0;
    end else if (cw) begin
      hist[0] <= cand;
      for (int i = 1; i < HN; i++) hist[i] <= hist[i-1];
      hv <= {hv[HN-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg    <= '0;
      have_q <= 1'b0;
    end else if (upd) begin
      msg    <= cand;
      have_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msg_rx <= 1'b0;
    else if (upd) msg_rx <= 1'b1;
    else if (flag_clr) msg_rx <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msg_match <= 1'b0;
    else if (qual && cand == match_val) msg_match <= 1'b1;
    else if (flag_clr) msg_match <= 1'b0;
  end

  p_rx_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_rx && !flag_clr) |=> msg_rx);
  p_mt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_match && !flag_clr) |=> msg_match);
  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !upd) |=> !msg_rx);
  p_msg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(msg));
  p_msg_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !msg[W-1] && !msg[0]);
  p_rx_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_rx) |-> (!$past(have_q) || $past(msg) != msg));
  p_mt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_match) |-> $past(qual && cand == match_val));
endmodule

// File: tb/bom_rx_tb_top.sv
`timescale 1ns/1ps
module bom_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dl_bit = 1'b0, dl_vld = 1'b0, flag_clr = 1'b0;
  logic [7:0] match_val = 8'h00;
  logic [7:0] msg;
  logic       msg_rx, msg_match;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  bom_rx dut_i (
    .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .dl_vld(dl_vld),
    .match_val(match_val), .flag_clr(flag_clr),
    .msg(msg), .msg_rx(msg_rx), .msg_match(msg_match)
  );

  // row: {clr_before, field, match_val, exp_msg, {6'b0, exp_rx, exp_mt}}
  localparam int NV = 19;
  localparam logic [39:0] VEC [NV] = '{
    40'h00_42_42_00_00, 40'h00_42_42_00_00, 40'h00_42_42_00_00,
    40'h00_42_42_00_00, 40'h00_42_42_00_00, 40'h00_42_42_00_00,
    40'h00_42_42_00_00,                                  // R3: 7 is not enough
    40'h00_42_42_42_03,                                  // R3 R6 R7: 8th accepts
    40'h01_42_42_42_01,                                  // R5: repeat, rx not re-set
    40'h01_18_42_42_00,
    40'h00_42_42_42_01,
    40'h01_18_42_42_00, 40'h00_18_42_42_00, 40'h00_18_42_42_00,
    40'h00_18_42_42_00, 40'h00_18_42_42_00, 40'h00_18_42_42_00,
    40'h00_18_42_18_02,                                  // R4 R6: two interlopers, R7 no match
    40'h00_18_18_18_03                                   // R7: match
  };

  task automatic chk(input string tag, input logic [7:0] em, input logic er, input logic et);
    n_chk++;
    if (msg !== em || msg_rx !== er || msg_match !== et) begin
      n_fail++;
      $display("FAIL %s: msg=%h rx=%b mt=%b expected msg=%h rx=%b mt=%b",
               tag, msg, msg_rx, msg_match, em, er, et);
    end
  endtask

  task automatic send_bit(input logic b, input logic cl);
    @(negedge clk);
    dl_bit = b; dl_vld = 1'b1; flag_clr = cl;
  endtask

  task automatic idle(input int n, input logic junk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      dl_vld = 1'b0; flag_clr = 1'b0; dl_bit = junk ^ k[0];
    end
  endtask

  task automatic send_cw(input logic [7:0] f, input bit gaps, input bit clr_last);
    for (int i = 0; i < 8; i++) begin
      send_bit(1'b1, 1'b0);
      if (gaps) idle(2, 1'b0);
    end
    for (int i = 7; i >= 0; i--) begin
      send_bit(f[i], clr_last && i == 0);
      if (gaps && i != 0) idle(1, 1'b1);
    end
    idle(1, 1'b0);
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1; dl_vld = 1'b0;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); chk("R1 in reset", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); chk("R1 after reset", 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); chk("R1 after reset", 8'h00, 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][32]) pulse_clr();
      match_val = VEC[v][23:16];
      send_cw(VEC[v][31:24], 1'b0, 1'b0);
      chk($sformatf("R3/R4/R5/R6/R7 vector %0d", v), VEC[v][15:8], VEC[v][1], VEC[v][0]);
    end

    // R2: fields with a 1 at either boundary never qualify
    do_reset();
    match_val = 8'h43;
    for (int k = 0; k < 10; k++) send_cw(8'h43, 1'b0, 1'b0);
    chk("R2 last bit 1 ignored", 8'h00, 1'b0, 1'b0);
    for (int k = 0; k < 10; k++) send_cw(8'hC2, 1'b0, 1'b0);
    chk("R2 first bit 1 ignored", 8'h00, 1'b0, 1'b0);

    // R9 + R2 bit order + R3 boundary from a clean history
    do_reset();
    match_val = 8'h00;
    for (int k = 0; k < 7; k++) send_cw(8'h34, 1'b1, 1'b0);
    chk("R3 seven with gaps", 8'h00, 1'b0, 1'b0);
    send_cw(8'h34, 1'b1, 1'b0);
    chk("R9 R2 gapped accept, first bit in msg[7]", 8'h34, 1'b1, 1'b0);

    // R8: clear alone, then set and clear together
    pulse_clr();
    chk("R8 clear keeps msg", 8'h34, 1'b0, 1'b0);
    match_val = 8'h5A;
    for (int k = 0; k < 7; k++) send_cw(8'h5A, 1'b0, 1'b0);
    chk("R4 seven of new value", 8'h34, 1'b0, 1'b0);
    send_cw(8'h5A, 1'b0, 1'b1);
    chk("R8 set wins over clear", 8'h5A, 1'b1, 1'b1);
    pulse_clr();
    chk("R8 clear both flags", 8'h5A, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule